// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control and status words on a simple memory-mapped bus. A byte address selects one word, and separate read and write strobes start an access. Read data comes from a register one clock after the read strobe. Most words are plain storage that software can read and write. A few words have fixed behaviour:

- Two clock-generator status words load fixed values at reset.
- One of those status words cannot be written.
- Three memory-remap control words always keep their reset contents. A write that would change one of them raises a one-cycle flag.
- One clock-configuration word is loaded at reset with a code for each of two peripheral-bus clock divisors. Both divisors are set by parameters.

An access whose word index falls beyond the bank raises a one-cycle error output.

Each divisor parameter must be a power of two no larger than 32. Any other value stops elaboration with an error. The block does not model clock division, clock-generator lock behaviour or actual memory remapping. It only holds the register state that such logic would read.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. The two low address bits do not change which word is accessed.
- R2: When `rd_en` is sampled high, `rdata` shows the addressed word on the next clock edge and holds that value until the next read. A read and a write to the same word in the same cycle return the value from before the write.
- R3: Every word other than the ones listed in R6 to R9 stores `wdata` on a write and returns it on a later read. Reset clears each such word to zero.
- R4: A read whose index is NREGS or more returns zero on `rdata`. `bad_offset` is high for the one cycle after the access.
- R5: A write whose index is NREGS or more changes no word. `bad_offset` is high for the one cycle after the access.
- R6: At reset, word index 10 (byte 0x028) loads 0x021A2358 and word index 11 (byte 0x02C) loads 0x00000003.
- R7: At reset, word index 5 (byte 0x014) loads a value with these fields:
  - bits 7:5 hold the code for divisor DIV0;
  - bits 4:2 hold the code for divisor DIV1;
  - all other bits are zero.
  The code is the trailing-zero count of the divisor for divisors below 8, and that count plus one for 8 and above: 1→0, 2→1, 4→2, 8→4, 16→5, 32→6. With the defaults DIV0 = DIV1 = 2 the word is 0x24. With DIV0 = 32 and DIV1 = 8 it is 0xD0.
- R8: Writes to word index 11 are ignored, and the word keeps its value.
- R9: Word indices 0, 1 and 3 (bytes 0x000, 0x004, 0x00C) keep their reset value of zero through any write. `remap_flag` is high for the one cycle after a write to one of them whose data differs from the stored value. It stays low when the data matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_offset | output | 1 | One-cycle pulse after an out-of-bank access |
| remap_flag | output | 1 | One-cycle pulse after a changing write to a remap word |

## Verification
The assertions assume that the strobes and the address are stable and valid at each rising edge. They also assume that every special index lies inside the bank, so the status and remap words exist to be held stable. The bench changes inputs only on falling edges and drives one access per strobe cycle. It chooses addresses on both sides of the bank limit and uses write data both equal to and different from the remap contents. A second instance with non-default divisors checks the higher divisor codes.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int NREGS      = 64,
  parameter int ADDR_W     = 10,
  parameter int DIV0       = 2,
  parameter int DIV1       = 2,
  parameter int IDX_SRAM   = 0,
  parameter int IDX_DDR    = 1,
  parameter int IDX_NVM    = 3,
  parameter int IDX_CLKCFG = 5,
  parameter int IDX_PLL_LO = 10,
  parameter int IDX_PLL_ST = 11,
  parameter logic [31:0] PLL_LO_INIT = 32'h021A2358,
  parameter logic [31:0] PLL_ST_INIT = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              bad_offset,
  output logic              remap_flag
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  function automatic bit div_ok(input int d);
    return (d > 0) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  function automatic int div_code(input int d);
    int tz = 0;
    for (int b = 5; b >= 0; b--)
      if (d[b]) tz = b;
    return (d < 8) ? tz : tz + 1;
  endfunction

  localparam logic [31:0] CLKCFG_INIT = 32'((div_code(DIV0) << 5) | (div_code(DIV1) << 2));

  if (!div_ok(DIV0) || !div_ok(DIV1)) begin : g_bad_div
    $error("divisor parameters must be powers of two no larger than 32");
  end

  function automatic logic [31:0] init_val(input int i);
    if (i == IDX_PLL_LO) return PLL_LO_INIT;
    if (i == IDX_PLL_ST) return PLL_ST_INIT;
    if (i == IDX_CLKCFG) return CLKCFG_INIT;
    return 32'h0;
  endfunction

  logic [31:0]      regs [NREGS];
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic             in_range, is_ro, is_remap, wr_ok;

  assign idx      = addr[ADDR_W-1:2];
  assign sel      = idx[SEL_W-1:0];
  assign in_range = ({{(32-IDX_W){1'b0}}, idx} < 32'(NREGS));
  assign is_ro    = (idx == IDX_W'(IDX_PLL_ST));
  assign is_remap = (idx == IDX_W'(IDX_SRAM)) || (idx == IDX_W'(IDX_DDR)) ||
                    (idx == IDX_W'(IDX_NVM));
  assign wr_ok    = wr_en && in_range && !is_ro && !is_remap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= init_val(i);
      rdata      <= '0;
      bad_offset <= 1'b0;
      remap_flag <= 1'b0;
    end else begin
      if (wr_ok) regs[sel] <= wdata;
      if (rd_en) rdata <= in_range ? regs[sel] : 32'h0;
      bad_offset <= (rd_en || wr_en) && !in_range;
      remap_flag <= wr_en && in_range && is_remap && (wdata != regs[sel]);
    end
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[IDX_PLL_ST])); // R8
  AST_REMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[IDX_SRAM]) && $stable(regs[IDX_DDR]) && $stable(regs[IDX_NVM])); // R9
  AST_FLAG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    remap_flag |-> $past(wr_en)); // R9
  AST_OOB_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> (rdata == 32'h0 && bad_offset)); // R4
  AST_OOB_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> (bad_offset && !remap_flag)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2
endmodule

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rdata1;
  logic bad_offset, remap_flag, bad1, flag1;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sysctl_regbank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .bad_offset(bad_offset), .remap_flag(remap_flag));
  sysctl_regbank #(.DIV0(32), .DIV1(8)) u1 (.clk(clk), .rst_n(rst_n), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata1), .bad_offset(bad1),
    .remap_flag(flag1));

  // {req, wr, rd, addr, wdata, exp_rdata, exp_err, exp_flag}
  localparam int NV = 20;
  localparam logic [81:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b1, 10'h050, 32'h0,        32'h0,        1'b0, 1'b0}, // R3 reset zero
    {4'd3, 1'b1, 1'b0, 10'h008, 32'hDEADBEEF, 32'h0,        1'b0, 1'b0}, // R3
    {4'd3, 1'b0, 1'b1, 10'h008, 32'h0,        32'hDEADBEEF, 1'b0, 1'b0}, // R3
    {4'd1, 1'b0, 1'b1, 10'h00B, 32'h0,        32'hDEADBEEF, 1'b0, 1'b0}, // R1
    {4'd3, 1'b1, 1'b0, 10'h0FC, 32'h12345678, 32'h0,        1'b0, 1'b0}, // R3 last word
    {4'd1, 1'b0, 1'b1, 10'h0FD, 32'h0,        32'h12345678, 1'b0, 1'b0}, // R1
    {4'd4, 1'b0, 1'b1, 10'h100, 32'h0,        32'h0,        1'b1, 1'b0}, // R4 first beyond
    {4'd5, 1'b1, 1'b0, 10'h3FC, 32'hFFFFFFFF, 32'h0,        1'b1, 1'b0}, // R5
    {4'd5, 1'b0, 1'b1, 10'h0FC, 32'h0,        32'h12345678, 1'b0, 1'b0}, // R5 unchanged
    {4'd8, 1'b1, 1'b0, 10'h02C, 32'h0,        32'h0,        1'b0, 1'b0}, // R8
    {4'd8, 1'b0, 1'b1, 10'h02C, 32'h0,        32'h3,        1'b0, 1'b0}, // R8
    {4'd9, 1'b1, 1'b0, 10'h000, 32'h5,        32'h0,        1'b0, 1'b1}, // R9 change
    {4'd9, 1'b0, 1'b1, 10'h000, 32'h0,        32'h0,        1'b0, 1'b0}, // R9
    {4'd9, 1'b1, 1'b0, 10'h004, 32'h0,        32'h0,        1'b0, 1'b0}, // R9 equal
    {4'd9, 1'b1, 1'b0, 10'h00C, 32'h1,        32'h0,        1'b0, 1'b1}, // R9
    {4'd9, 1'b0, 1'b1, 10'h00C, 32'h0,        32'h0,        1'b0, 1'b0}, // R9
    {4'd6, 1'b0, 1'b1, 10'h028, 32'h0,        32'h021A2358, 1'b0, 1'b0}, // R6
    {4'd7, 1'b0, 1'b1, 10'h014, 32'h0,        32'h24,       1'b0, 1'b0}, // R7
    {4'd2, 1'b1, 1'b1, 10'h008, 32'h1,        32'hDEADBEEF, 1'b0, 1'b0}, // R2 old value
    {4'd2, 1'b0, 1'b1, 10'h008, 32'h0,        32'h1,        1'b0, 1'b0}  // R2
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(3, "reset rdata", rdata, 32'h0);
    chk(4, "reset bad_offset", {31'b0, bad_offset}, 32'h0);
    chk(9, "reset remap_flag", {31'b0, remap_flag}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][77], VEC[i][76], VEC[i][75:66], VEC[i][65:34]);
      if (VEC[i][76]) chk(int'(VEC[i][81:78]), "rdata", rdata, VEC[i][33:2]);
      chk(int'(VEC[i][81:78]), "bad_offset", {31'b0, bad_offset}, {31'b0, VEC[i][1]});
      chk(int'(VEC[i][81:78]), "remap_flag", {31'b0, remap_flag}, {31'b0, VEC[i][0]});
    end
    // R7: high divisor codes on the second instance
    op(0, 1, 10'h014, 32'h0);
    chk(7, "clkcfg 32/8", rdata1, 32'hD0);
    // R2: rdata holds with no read strobe
    op(1, 0, 10'h020, 32'hA5A5A5A5);
    chk(2, "rdata hold", rdata, 32'hD0 ^ 32'hD0 ^ 32'h24);
    // R3: a second reset clears stored words
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    op(0, 1, 10'h008, 32'h0);
    chk(3, "cleared after reset", rdata, 32'h0);
    op(0, 1, 10'h02C, 32'h0);
    chk(6, "status after reset", rdata, 32'h3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule